// File: doc/BRIEF.md
# DVMA Address Translation Unit

This block turns 32-bit device virtual addresses into physical addresses for a device port. The mapping lives in memory as a flat table of 64-bit entries with one entry per 8 KB page. The mapped window always ends at the top of the 32-bit space, and its size comes from a 3-bit code in the control word. Software sets up the unit through a small write-only register bus. The three registers are control (address 0), table base (address 1) and flush (address 2). A write to address 3 is dropped.

A request enters on a valid/ready port. The unit checks that the address falls inside the window. It then takes the entry from its one-entry translation cache or reads it over a memory read port. It checks the entry's valid and writable bits and returns either a physical address or a fault with a cause code.

Back-pressure rules:
- Only one request is handled at a time. `req_ready` is low from the acceptance cycle until the response handshake completes.
- A response stays valid and stable until `rsp_ready` is seen high.
- A memory read request stays valid with a stable address until `mem_req_ready` is seen high.
- A memory response is a single-cycle pulse on `mem_rsp_valid` and has no back-pressure.

Top module: `dvma_xlate`

## Requirements
- R1: After reset, `req_ready` is 1, `rsp_valid` is 0, `mem_req_valid` is 0 and the translation cache is empty.
- R2: When control bit 0 is clear, an accepted request responds in the next cycle with `rsp_fault`=1 and cause 0 (disabled). No memory read is issued, even when the page is cached.
- R3: The window base is 0xFF800000 shifted left by the size code in control bits 18:16, kept to 32 bits (0xFF800000 for code 0, 0xC0000000 for code 7). A request below the base faults with cause 1 after one cycle and issues no memory read.
- R4: The entry address is {base register bits 40:13, 13 zero bits} plus 8 times ((address − window base) >> 13).
- R5: A fetched entry with bit 63 clear gives a fault with cause 2. Such an entry is not cached.
- R6: A write request to a page whose entry bit 1 is clear faults with cause 3. A read of the same page succeeds.
- R7: A successful response has `rsp_fault`=0 and `rsp_paddr` = {entry bits 40:13, request address bits 12:0}. A fault response carries `rsp_paddr`=0.
- R8: A fetched entry with bit 63 set is cached under its page number (address bits 31:13). A later request to that page responds one cycle after acceptance with no memory read.
- R9: A write to the flush register clears the cached translation when write-data bits 31:13 equal its page. Any other flush value leaves the cached translation in place.
- R10: `req_ready` is low from acceptance until the response handshake. A response held by `rsp_ready`=0 keeps its values. A memory request held by `mem_req_ready`=0 keeps its address.
- R11: Control bit 2 and entry bits 61, 60, 59 and 4 do not change any response.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register select: 0 control, 1 table base, 2 flush |
| reg_wdata | input | 64 | Register write data |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Request accepted when high with `req_valid` |
| req_addr | input | 32 | Device virtual address |
| req_write | input | 1 | Request is a write |
| rsp_valid | output | 1 | Response valid |
| rsp_ready | input | 1 | Response taken when high with `rsp_valid` |
| rsp_fault | output | 1 | Translation failed |
| rsp_cause | output | 2 | Fault cause: 0 disabled, 1 outside window, 2 invalid entry, 3 write-protected |
| rsp_paddr | output | 41 | Physical address (0 on fault) |
| mem_req_valid | output | 1 | Table entry read request |
| mem_req_ready | input | 1 | Memory accepts the read |
| mem_req_addr | output | 41 | Byte address of the table entry |
| mem_rsp_valid | input | 1 | Entry data valid (one-cycle pulse) |
| mem_rsp_data | input | 64 | Table entry |

## Verification
The assertions assume that `mem_rsp_valid` pulses only after a read has been accepted and only once for each read. They also assume that the flush register is not written while a table read is outstanding. The bench's memory model answers exactly once, two cycles after each accepted read. All register writes are issued between requests, after the previous response handshake. Under those conditions the bench's model decides, for each request, whether a read must happen, at which address, and which result comes back. The per-clock monitor checks the one-in-flight and fault-address rules on every cycle.

// File: rtl/dvma_pkg.sv
package dvma_pkg;

  typedef enum logic [1:0] {
    CAUSE_DIS   = 2'd0,
    CAUSE_WIN   = 2'd1,
    CAUSE_INV   = 2'd2,
    CAUSE_WPROT = 2'd3
  } cause_e;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_FETCH,
    ST_WAIT,
    ST_RESP
  } xl_state_e;

endpackage

// File: rtl/dvma_window.sv
module dvma_window #(
  parameter int VA_W         = 32,
  parameter int PG           = 13,
  parameter int SZ_W         = 3,
  parameter int TBL_MIN_LOG2 = 10,
  parameter int IDX_W        = 17
) (
  input  logic [SZ_W-1:0]  size_code,
  input  logic [VA_W-1:0]  va,
  output logic             in_win,
  output logic [IDX_W-1:0] idx
);
  localparam logic [VA_W-1:0] WIN_SMALLEST = {VA_W{1'b1}} << (PG + TBL_MIN_LOG2);

  logic [VA_W-1:0] base;
  logic [VA_W-1:0] offset;

  assign base   = WIN_SMALLEST << size_code;
  assign offset = va - base;
  assign in_win = (va >= base);
  assign idx    = offset[PG+IDX_W-1:PG];

  logic unused_offset;
  assign unused_offset = ^{offset[VA_W-1:PG+IDX_W], offset[PG-1:0]};

endmodule

// File: rtl/dvma_pte_check.sv
module dvma_pte_check
  import dvma_pkg::*;
#(
  parameter int PA_W = 41,
  parameter int PG   = 13
) (
  input  logic               ent_valid,
  input  logic               ent_writable,
  input  logic [PA_W-PG-1:0] ent_ppn,
  input  logic [PG-1:0]      page_off,
  input  logic               is_write,
  output logic               fault,
  output cause_e             cause,
  output logic [PA_W-1:0]    paddr
);
  always_comb begin
    fault = 1'b0;
    cause = CAUSE_DIS;
    paddr = {ent_ppn, page_off};
    if (!ent_valid) begin
      fault = 1'b1;
      cause = CAUSE_INV;
    end else if (is_write && !ent_writable) begin
      fault = 1'b1;
      cause = CAUSE_WPROT;
    end
    if (fault) paddr = '0;
  end

endmodule

// File: rtl/dvma_tcache.sv
module dvma_tcache #(
  parameter int VPN_W = 19,
  parameter int PPN_W = 28
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [VPN_W-1:0] lk_page,
  output logic             hit,
  output logic [PPN_W-1:0] hit_ppn,
  output logic             hit_writable,
  input  logic             fill_en,
  input  logic [VPN_W-1:0] fill_page,
  input  logic [PPN_W-1:0] fill_ppn,
  input  logic             fill_writable,
  input  logic             flush_en,
  input  logic [VPN_W-1:0] flush_page
);
  logic             held;
  logic [VPN_W-1:0] tag;
  logic [PPN_W-1:0] ppn;
  logic             wr_ok;
  logic [VPN_W-1:0] next_tag;

  assign next_tag = fill_en ? fill_page : tag;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      held  <= 1'b0;
      tag   <= '0;
      ppn   <= '0;
      wr_ok <= 1'b0;
    end else begin
      if (fill_en) begin
        held  <= 1'b1;
        tag   <= fill_page;
        ppn   <= fill_ppn;
        wr_ok <= fill_writable;
      end
      if (flush_en && (next_tag == flush_page)) held <= 1'b0;
    end
  end

  assign hit          = held && (tag == lk_page);
  assign hit_ppn      = ppn;
  assign hit_writable = wr_ok;

  AST_FLUSH_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (flush_en && !fill_en && hit && (lk_page == flush_page)) |=> !held); // R9

  AST_FILL_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (fill_en && !flush_en) |=> held); // R8

endmodule

// File: rtl/dvma_xlate.sv
module dvma_xlate
  import dvma_pkg::*;
#(
  parameter int VA_W         = 32,
  parameter int PA_W         = 41,
  parameter int PG           = 13,
  parameter int SZ_W         = 3,
  parameter int TBL_MIN_LOG2 = 10,
  parameter int ENT_W        = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             reg_we,
  input  logic [1:0]       reg_addr,
  input  logic [63:0]      reg_wdata,
  input  logic             req_valid,
  output logic             req_ready,
  input  logic [VA_W-1:0]  req_addr,
  input  logic             req_write,
  output logic             rsp_valid,
  input  logic             rsp_ready,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             mem_req_valid,
  input  logic             mem_req_ready,
  output logic [PA_W-1:0]  mem_req_addr,
  input  logic             mem_rsp_valid,
  input  logic [ENT_W-1:0] mem_rsp_data
);
  localparam int VPN_W     = VA_W - PG;
  localparam int PPN_W     = PA_W - PG;
  localparam int IDX_W     = TBL_MIN_LOG2 + (1 << SZ_W) - 1;
  localparam int ENT_SHIFT = $clog2(ENT_W / 8);
  localparam int V_BIT     = ENT_W - 1;
  localparam int W_BIT     = 1;
  localparam int SZ_LO     = 16;
  localparam logic [1:0] A_CTRL  = 2'd0;
  localparam logic [1:0] A_BASE  = 2'd1;
  localparam logic [1:0] A_FLUSH = 2'd2;

  // Registers written by software
  logic            ctrl_en;
  logic [SZ_W-1:0] ctrl_code;
  logic [PPN_W-1:0] tbase_ppn;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ctrl_en   <= 1'b0;
      ctrl_code <= '0;
      tbase_ppn <= '0;
    end else if (reg_we) begin
      if (reg_addr == A_CTRL) begin
        ctrl_en   <= reg_wdata[0];
        ctrl_code <= reg_wdata[SZ_LO+SZ_W-1:SZ_LO];
      end
      if (reg_addr == A_BASE) tbase_ppn <= reg_wdata[PA_W-1:PG];
    end
  end

  logic flush_en;
  assign flush_en = reg_we && (reg_addr == A_FLUSH);

  // Request-side state
  xl_state_e       state;
  logic [VA_W-1:0] va_q;
  logic            wr_q;
  logic [PA_W-1:0] fetch_addr_q;
  logic            res_fault;
  cause_e          res_cause;
  logic [PA_W-1:0] res_paddr;

  // Window and slot
  logic             in_win;
  logic [IDX_W-1:0] idx;
  logic [PA_W-1:0]  ent_addr;

  dvma_window #(
    .VA_W(VA_W), .PG(PG), .SZ_W(SZ_W), .TBL_MIN_LOG2(TBL_MIN_LOG2), .IDX_W(IDX_W)
  ) u_window (
    .size_code(ctrl_code),
    .va       (req_addr),
    .in_win   (in_win),
    .idx      (idx)
  );

  assign ent_addr = {tbase_ppn, {PG{1'b0}}} + PA_W'({idx, {ENT_SHIFT{1'b0}}});

  // Translation cache
  logic             hit;
  logic [PPN_W-1:0] hit_ppn;
  logic             hit_writable;
  logic             fill_en;

  assign fill_en = (state == ST_WAIT) && mem_rsp_valid && mem_rsp_data[V_BIT];

  dvma_tcache #(.VPN_W(VPN_W), .PPN_W(PPN_W)) u_cache (
    .clk          (clk),
    .rst_n        (rst_n),
    .lk_page      (req_addr[VA_W-1:PG]),
    .hit          (hit),
    .hit_ppn      (hit_ppn),
    .hit_writable (hit_writable),
    .fill_en      (fill_en),
    .fill_page    (va_q[VA_W-1:PG]),
    .fill_ppn     (mem_rsp_data[PA_W-1:PG]),
    .fill_writable(mem_rsp_data[W_BIT]),
    .flush_en     (flush_en),
    .flush_page   (reg_wdata[VA_W-1:PG])
  );

  // One permission check, fed by the cache in IDLE and by memory in WAIT
  logic             sel_mem;
  logic             chk_fault;
  cause_e           chk_cause;
  logic [PA_W-1:0]  chk_paddr;

  assign sel_mem = (state == ST_WAIT);

  dvma_pte_check #(.PA_W(PA_W), .PG(PG)) u_check (
    .ent_valid   (sel_mem ? mem_rsp_data[V_BIT] : 1'b1),
    .ent_writable(sel_mem ? mem_rsp_data[W_BIT] : hit_writable),
    .ent_ppn     (sel_mem ? mem_rsp_data[PA_W-1:PG] : hit_ppn),
    .page_off    (sel_mem ? va_q[PG-1:0] : req_addr[PG-1:0]),
    .is_write    (sel_mem ? wr_q : req_write),
    .fault       (chk_fault),
    .cause       (chk_cause),
    .paddr       (chk_paddr)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state        <= ST_IDLE;
      va_q         <= '0;
      wr_q         <= 1'b0;
      fetch_addr_q <= '0;
      res_fault    <= 1'b0;
      res_cause    <= CAUSE_DIS;
      res_paddr    <= '0;
    end else begin
      unique case (state)
        ST_IDLE: if (req_valid) begin
          va_q <= req_addr;
          wr_q <= req_write;
          if (!ctrl_en) begin
            res_fault <= 1'b1;
            res_cause <= CAUSE_DIS;
            res_paddr <= '0;
            state     <= ST_RESP;
          end else if (!in_win) begin
            res_fault <= 1'b1;
            res_cause <= CAUSE_WIN;
            res_paddr <= '0;
            state     <= ST_RESP;
          end else if (hit) begin
            res_fault <= chk_fault;
            res_cause <= chk_cause;
            res_paddr <= chk_paddr;
            state     <= ST_RESP;
          end else begin
            fetch_addr_q <= ent_addr;
            state        <= ST_FETCH;
          end
        end
        ST_FETCH: if (mem_req_ready) state <= ST_WAIT;
        ST_WAIT: if (mem_rsp_valid) begin
          res_fault <= chk_fault;
          res_cause <= chk_cause;
          res_paddr <= chk_paddr;
          state     <= ST_RESP;
        end
        ST_RESP: if (rsp_ready) state <= ST_IDLE;
        default: state <= ST_IDLE;
      endcase
    end
  end

  assign req_ready     = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_FETCH);
  assign mem_req_addr  = fetch_addr_q;
  assign rsp_valid     = (state == ST_RESP);
  assign rsp_fault     = res_fault;
  assign rsp_cause     = res_cause;
  assign rsp_paddr     = res_paddr;

  logic unused_bits;
  assign unused_bits = ^{reg_wdata[63:PA_W], reg_wdata[SZ_LO-1:1],
                         mem_rsp_data[V_BIT-1:PA_W], mem_rsp_data[PG-1:W_BIT+1],
                         mem_rsp_data[0]};

  AST_ONE_IN_FLIGHT: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready) |=> !req_ready); // R10

  AST_RSP_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_paddr) &&
                                   $stable(rsp_cause) && $stable(rsp_fault))); // R10

  AST_MEM_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr))); // R10

  AST_DIS_NO_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && !ctrl_en) |=>
      (rsp_valid && rsp_fault && rsp_cause == CAUSE_DIS && !mem_req_valid)); // R2

  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> (rsp_paddr == '0)); // R7

  AST_IDX_IN_TABLE: assert property (@(posedge clk) disable iff (!rst_n)
    in_win |-> ((idx >> (TBL_MIN_LOG2 + int'(ctrl_code))) == '0)); // R3

endmodule

// File: tb/tb_dvma_xlate.sv
module tb_dvma_xlate;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0;
  logic [1:0]  reg_addr = '0;
  logic [63:0] reg_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_addr = '0;
  logic        req_write = 1'b0;
  logic        rsp_valid;
  logic        rsp_ready = 1'b0;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;
  logic [40:0] rsp_paddr;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b1;
  logic [40:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;

  always #4 clk = ~clk;

  dvma_xlate dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr), .req_write(req_write),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause),
    .rsp_paddr(rsp_paddr), .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid), .mem_rsp_data(mem_rsp_data)
  );

  int vectors = 0;
  int miscompares = 0;
  int fetches = 0;
  int pend = 0;
  int stall_ctr = 0;
  int mem_stall = 0;
  int cycles = 0;
  logic busy = 1'b0;
  logic [40:0] last_fetch = '0;
  logic [63:0] mem [logic [40:0]];

  // Reference model state
  logic        m_en = 1'b0;
  logic [2:0]  m_code = '0;
  logic [40:0] m_tbase = '0;
  logic        mc_valid = 1'b0;
  logic [18:0] mc_page = '0;
  logic [63:0] mc_ent = '0;

  localparam logic [40:0] TBASE = 41'h12_3456_0000;

  function automatic logic [63:0] rd_mem(logic [40:0] a);
    if (mem.exists(a)) return mem[a];
    return 64'h0;
  endfunction

  function automatic logic [63:0] mk_pte(logic [27:0] ppn, logic v, logic w);
    logic [63:0] e = '0;
    e[63] = v;
    e[1] = w;
    e[40:13] = ppn;
    return e;
  endfunction

  function automatic logic [40:0] model_eaddr(logic [31:0] va);
    logic [31:0] wb = 32'hFF80_0000 << m_code;
    return m_tbase + 41'((va - wb) >> 13) * 41'd8;
  endfunction

  task automatic chk(string r, string what, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s %s: actual %h expected %h", r, what, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
    $finish;
  endtask

  // Memory model: accepts reads, answers with a one-cycle pulse two cycles later
  always @(posedge clk) begin
    cycles++;
    if (mem_req_valid && mem_req_ready) begin
      fetches++;
      last_fetch = mem_req_addr;
      pend = 2;
    end
    if (cycles >= 100000) begin
      miscompares++;
      $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
      finish_run();
    end
  end

  always @(negedge clk) begin
    if (pend == 1) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = rd_mem(last_fetch);
    end else begin
      mem_rsp_valid = 1'b0;
    end
    if (pend > 0) pend--;
    mem_req_ready = (stall_ctr == 0);
    if (mem_req_valid && stall_ctr > 0) stall_ctr--;
  end

  // Per-clock monitor
  always @(negedge clk) begin
    #1;
    if (rst_n) begin
      if (busy) chk("R10", "ready while in flight", 64'(req_ready), 64'd0);
      if (rsp_valid && rsp_fault) chk("R7", "fault paddr", 64'(rsp_paddr), 64'd0);
    end
  end

  task automatic wr_reg(input logic [1:0] a, input logic [63:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
    if (a == 2'd0) begin m_en = d[0]; m_code = d[18:16]; end
    if (a == 2'd1) m_tbase = {d[40:13], 13'b0};
    if (a == 2'd2 && mc_valid && mc_page == d[31:13]) mc_valid = 1'b0;
  endtask

  task automatic set_pte(input logic [31:0] va, input logic [63:0] e);
    mem[model_eaddr(va)] = e;
  endtask

  task automatic predict(input logic [31:0] va, input logic wr, output logic ef,
                         output logic [1:0] ec, output logic [40:0] epa,
                         output logic efetch, output logic [40:0] eea);
    logic [31:0] wb;
    logic [63:0] e;
    ef = 1'b1; ec = 2'd0; epa = '0; efetch = 1'b0; eea = '0;
    if (!m_en) return;
    wb = 32'hFF80_0000 << m_code;
    if (va < wb) begin ec = 2'd1; return; end
    if (mc_valid && mc_page == va[31:13]) begin
      e = mc_ent;
    end else begin
      efetch = 1'b1;
      eea = model_eaddr(va);
      e = rd_mem(eea);
      if (e[63]) begin mc_valid = 1'b1; mc_page = va[31:13]; mc_ent = e; end
    end
    if (!e[63]) ec = 2'd2;
    else if (wr && !e[1]) ec = 2'd3;
    else begin ef = 1'b0; epa = {e[40:13], va[12:0]}; end
  endtask

  task automatic run_req(input logic [31:0] va, input logic wr, input int hold, input string r);
    logic ef, efetch, cf;
    logic [1:0] ec, cc;
    logic [40:0] epa, eea, cpa;
    int f0;
    int n;
    predict(va, wr, ef, ec, epa, efetch, eea);
    f0 = fetches;
    stall_ctr = mem_stall;
    @(negedge clk);
    chk(r, "ready before request", 64'(req_ready), 64'd1);
    req_valid = 1'b1; req_addr = va; req_write = wr;
    @(negedge clk);
    req_valid = 1'b0;
    busy = 1'b1;
    if (!efetch) chk(r, "response one cycle after accept", 64'(rsp_valid), 64'd1);
    n = 0;
    while (!rsp_valid && n < 64) begin @(negedge clk); n++; end
    cf = rsp_fault; cc = rsp_cause; cpa = rsp_paddr;
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      chk("R10", "response held valid", 64'(rsp_valid), 64'd1);
      chk("R10", "response held stable", 64'({rsp_fault, rsp_cause, rsp_paddr}),
          64'({cf, cc, cpa}));
    end
    rsp_ready = 1'b1;
    @(negedge clk);
    rsp_ready = 1'b0;
    busy = 1'b0;
    chk(r, "fault flag", 64'(cf), 64'(ef));
    if (ef) chk(r, "fault cause", 64'(cc), 64'(ec));
    else chk(r, "physical address", 64'(cpa), 64'(epa));
    chk(r, "memory reads", 64'(fetches - f0), 64'(efetch));
    if (efetch) chk("R4", "entry address", 64'(last_fetch), 64'(eea));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1", "req_ready in reset release", 64'(req_ready), 64'd1);
    chk("R1", "rsp_valid after reset", 64'(rsp_valid), 64'd0);
    chk("R1", "mem_req_valid after reset", 64'(mem_req_valid), 64'd0);
    rst_n = 1'b1;

    run_req(32'hFFF0_0000, 1'b0, 0, "R2");

    wr_reg(2'd1, 64'(TBASE));
    wr_reg(2'd0, 64'h1);
    set_pte(32'hFF80_0000, mk_pte(28'h00A_BCDE, 1'b1, 1'b1));
    set_pte(32'hFF80_2000, mk_pte(28'h000_0123, 1'b1, 1'b0));
    set_pte(32'hFF80_4000, mk_pte(28'h555_5555, 1'b0, 1'b1));
    set_pte(32'hFFFF_E000, mk_pte(28'h777_7001, 1'b1, 1'b1));

    run_req(32'hFF7F_FFFF, 1'b0, 0, "R3");
    run_req(32'hFF80_0ABC, 1'b0, 0, "R7");
    run_req(32'hFF80_1FFF, 1'b1, 2, "R8");
    run_req(32'hFF80_2010, 1'b1, 0, "R6");
    run_req(32'hFF80_2010, 1'b0, 0, "R6");
    run_req(32'hFF80_4000, 1'b0, 0, "R5");
    run_req(32'hFF80_4008, 1'b0, 0, "R5");
    run_req(32'hFFFF_E777, 1'b0, 0, "R4");

    wr_reg(2'd2, 64'hFF80_0000);
    run_req(32'hFFFF_E000, 1'b0, 0, "R9");
    wr_reg(2'd2, 64'hFFFF_E5A5);
    run_req(32'hFFFF_E001, 1'b0, 0, "R9");

    wr_reg(2'd0, 64'h7_0001);
    set_pte(32'hC000_0000, mk_pte(28'h100_0000, 1'b1, 1'b1));
    set_pte(32'hC000_2000, mk_pte(28'h100_0001, 1'b1, 1'b0));
    set_pte(32'hFFFF_E000, mk_pte(28'h0FF_FFFF, 1'b1, 1'b0));
    run_req(32'hBFFF_FFFF, 1'b0, 0, "R3");
    run_req(32'hC000_0010, 1'b0, 0, "R4");
    run_req(32'hC000_3FFF, 1'b0, 0, "R4");
    run_req(32'hFFFF_E100, 1'b0, 0, "R8");
    wr_reg(2'd2, 64'hFFFF_E000);
    run_req(32'hFFFF_E100, 1'b0, 0, "R4");

    mem_stall = 3;
    run_req(32'hC000_0020, 1'b1, 4, "R10");
    mem_stall = 0;

    wr_reg(2'd0, 64'h7_0005);
    set_pte(32'hC001_0000, mk_pte(28'h0CA_FE00, 1'b1, 1'b1) | 64'h3800_0000_0000_0010);
    run_req(32'hC001_0444, 1'b1, 0, "R11");
    run_req(32'hC001_0445, 1'b0, 1, "R11");
    run_req(32'hC000_0040, 1'b0, 0, "R11");

    wr_reg(2'd0, 64'h7_0004);
    run_req(32'hC000_0040, 1'b0, 0, "R2");

    finish_run();
  end

endmodule